// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides when an external bus master may take over the local bus from the processor core. The other master raises a hold request and receives an acknowledge. The acknowledge is issued only at points where no core bus cycle is in progress. In the same clock edge that raises the acknowledge, the enable for the core's address, data and control drivers drops, so those lines float. A stall output keeps the core's bus sequencer idling while the drivers are off. When the request is withdrawn, the acknowledge falls. The drivers are turned on again only when the core has a bus cycle waiting.

The block runs on a clock at twice the T-state rate, so each T-state takes two clocks: a first half (phase 0) and a second half (phase 1). The sequencer reports the current T-state and phase. The request is treated as a synchronous input. A parameter inserts a two-flop synchronizer in front of it for systems that cannot guarantee setup time. When a grant opportunity and a waiting core cycle coincide, the external request wins.

Top module: `bus_hold_arb`

## Requirements
- R1: The acknowledge never rises unless the effective (post-synchronizer) request is high. The request is active high.
- R2: The acknowledge rises only at the clock edge that ends phase 0 of a T4 state or a Ti state. T-states are encoded T1=0, T2=1, T3=2, TW=3, T4=4, Ti=5. Phase 0 means the first half of a state.
- R3: The driver enable falls at the same edge at which the acknowledge rises.
- R4: While the acknowledge is high, the first edge that samples the effective request low clears the acknowledge. The driver enable stays low at that edge.
- R5: The driver enable rises only at an edge where the acknowledge was low and the core-cycle-pending flag was high. It does not rise at an edge where a new grant is taken.
- R6: The stall output is high exactly while the driver enable is low.
- R7: A synchronous active-high reset clears the acknowledge and the stall and sets the driver enable.
- R8: With SYNC_STAGES=2, the request reaches the grant logic two clocks late. With SYNC_STAGES=0, it is used in the same clock.
- R9: A request that arrives during T1, T2, T3 or TW of a cycle is not granted before phase 0 of that cycle's T4 has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Bus request from the external master |
| tstate | input | 3 | Current T-state from the sequencer |
| mid_phase | input | 1 | 0 = first half of the state, 1 = second half |
| cycle_pend | input | 1 | The core has a bus cycle waiting |
| hold_ack | output | 1 | Acknowledge to the external master |
| bus_drv_en | output | 1 | Enable for the core's bus and control drivers |
| seq_stall | output | 1 | Keeps the sequencer idling in Ti |

## Verification
The bench builds two copies of the block: one with SYNC_STAGES=2, the default, and one with SYNC_STAGES=0. Every cycle, both copies are compared with an arithmetic model that delays the request by the configured depth.

The stimulus first sweeps every combination of T-state, phase, request and pending flag. It then runs a long pseudo-random segment in which the request is held for runs of cycles, so that grant, hold, release and re-enable all occur from each phase. With the unsynchronized copy, the grant window and the release edge can be observed cycle-exactly. With the synchronized copy, the two-clock latency can be observed.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  localparam int TS_W = 3;
  typedef enum logic [TS_W-1:0] {
    TS_T1 = 3'd0,
    TS_T2 = 3'd1,
    TS_T3 = 3'd2,
    TS_TW = 3'd3,
    TS_T4 = 3'd4,
    TS_TI = 3'd5
  } tstate_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/grant_window.sv
module grant_window
  import bus_hold_pkg::*;
(
  input  logic [TS_W-1:0] tstate,
  input  logic            mid_phase,
  output logic            open_now
);
  always_comb begin
    open_now = 1'b0;
    if (!mid_phase) begin
      case (tstate)
        TS_T4, TS_TI: open_now = 1'b1;
        default:      open_now = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic open_now,
  input  logic cycle_pend,
  output logic hold_ack,
  output logic bus_drv_en,
  output logic seq_stall
);
  logic ack_n, drv_n;

  always_comb begin
    ack_n = hold_ack;
    drv_n = bus_drv_en;
    if (hold_ack) begin
      if (!req_s) ack_n = 1'b0;
    end else if (req_s && open_now) begin
      ack_n = 1'b1;
      drv_n = 1'b0;
    end else if (!bus_drv_en && cycle_pend) begin
      drv_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ack   <= 1'b0;
      bus_drv_en <= 1'b1;
      seq_stall  <= 1'b0;
    end else begin
      hold_ack   <= ack_n;
      bus_drv_en <= drv_n;
      seq_stall  <= !drv_n;
    end
  end

  p_req_needed_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(req_s));
  p_grant_window_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(open_now));
  p_float_with_ack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> !bus_drv_en);
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !req_s) |=> (!hold_ack && !bus_drv_en));
  p_reenable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_drv_en) |-> ($past(cycle_pend) && !$past(hold_ack)));
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    seq_stall == !bus_drv_en);
  p_ack_floats_r3: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !bus_drv_en);
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_req,
  input  logic [TS_W-1:0] tstate,
  input  logic            mid_phase,
  input  logic            cycle_pend,
  output logic            hold_ack,
  output logic            bus_drv_en,
  output logic            seq_stall
);
  logic req_s, open_now;

  initial begin
    assert (SYNC_STAGES == 0 || SYNC_STAGES >= 2)
      else $error("SYNC_STAGES must be 0 or at least 2 (R8)");
  end

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(hold_req), .q(req_s)
  );

  grant_window u_win (
    .tstate(tstate), .mid_phase(mid_phase), .open_now(open_now)
  );

  hold_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_s(req_s), .open_now(open_now),
    .cycle_pend(cycle_pend), .hold_ack(hold_ack),
    .bus_drv_en(bus_drv_en), .seq_stall(seq_stall)
  );
endmodule

// File: tb/bus_hold_arb_bench.sv
module bus_hold_arb_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0;
  logic [2:0] tstate = 3'd5;
  logic mid_phase = 1'b0;
  logic cycle_pend = 1'b0;
  logic ack2, drv2, stl2, ack0, drv0, stl0;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_hold_arb #(.SYNC_STAGES(2)) u_bus_hold_arb (
    .clk(clk), .rst(rst), .hold_req(hold_req), .tstate(tstate),
    .mid_phase(mid_phase), .cycle_pend(cycle_pend),
    .hold_ack(ack2), .bus_drv_en(drv2), .seq_stall(stl2));

  bus_hold_arb #(.SYNC_STAGES(0)) u_bus_hold_arb_nosync (
    .clk(clk), .rst(rst), .hold_req(hold_req), .tstate(tstate),
    .mid_phase(mid_phase), .cycle_pend(cycle_pend),
    .hold_ack(ack0), .bus_drv_en(drv0), .seq_stall(stl0));

  // reference state, index 0 = no synchronizer, 1 = two stages
  logic m_ack [2];
  logic m_drv [2];
  logic s1 = 1'b0, s2 = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic win;
    logic eff [2];
    win = (tstate == 3'd4 || tstate == 3'd5) && !mid_phase;
    eff[0] = hold_req;
    eff[1] = s2;
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_ack[k] = 1'b0; m_drv[k] = 1'b1;
      end else if (m_ack[k]) begin
        if (!eff[k]) m_ack[k] = 1'b0;
      end else if (eff[k] && win) begin
        m_ack[k] = 1'b1; m_drv[k] = 1'b0;
      end else if (!m_drv[k] && cycle_pend) begin
        m_drv[k] = 1'b1;
      end
    end
    if (rst) begin s1 = 1'b0; s2 = 1'b0; end
    else begin s2 = s1; s1 = hold_req; end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1/R2/R4/R9 ack nosync", ack0, m_ack[0]);
    chk("R3/R5 drv nosync", drv0, m_drv[0]);
    chk("R6 stall nosync", stl0, !m_drv[0]);
    chk("R8/R2/R4 ack sync2", ack2, m_ack[1]);
    chk("R8/R3/R5 drv sync2", drv2, m_drv[1]);
    chk("R6 stall sync2", stl2, !m_drv[1]);
  endtask

  initial begin
    m_ack[0] = 1'b0; m_ack[1] = 1'b0; m_drv[0] = 1'b1; m_drv[1] = 1'b1;
    @(negedge clk);
    hold_req = 1'b1;
    step(); step();
    // R7: reset state even with a request present
    chk("R7 ack reset", ack0, 1'b0);
    chk("R7 drv reset", drv0, 1'b1);
    chk("R7 stall reset", stl2, 1'b0);
    rst = 1'b0; hold_req = 1'b0;
    // R9: request raised in T1..TW is deferred to T4
    hold_req = 1'b1;
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 2; p++) begin
        tstate = 3'(t); mid_phase = p[0];
        step();
        chk("R9 no grant before T4", ack0, 1'b0);
      end
    end
    tstate = 3'd4; mid_phase = 1'b0; step();
    chk("R9 grant at T4 middle", ack0, 1'b1);
    chk("R3 float at grant", drv0, 1'b0);
    tstate = 3'd5; cycle_pend = 1'b1; hold_req = 1'b0; step();
    chk("R4 ack drops", ack0, 1'b0);
    step();
    chk("R5 drivers back", drv0, 1'b1);
    // exhaustive combination sweep
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 48; i++) begin
        tstate = 3'((i >> 3) % 6); mid_phase = i[0];
        hold_req = i[1]; cycle_pend = i[2] ^ rep[0];
        step();
      end
    end
    // long pseudo-random segment with held requests
    begin
      logic [15:0] lf = 16'hACE1;
      for (int c = 0; c < 4000; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tstate = 3'(lf[2:0] % 6); mid_phase = lf[3];
        cycle_pend = lf[4] & lf[5];
        if (lf[9:6] == 4'd0) hold_req = ~hold_req;
        step();
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule